// File: doc/BRIEF.md
# DMA Peripheral-Side Request Generator

This block sits next to the FIFO of a peripheral and asks a DMA engine for service. One parameter decides which way data flows. As a sink, the block counts the free slots in the FIFO. As a source, it counts the stored items. From that count it drives two lines. The first is a burst request, raised once the count reaches a programmable threshold. The second is a single-item line, raised whenever at least one item can move.

When a request is raised, both lines are held until the engine acknowledges. The block then drops them and waits for the acknowledge to fall before it arms again, which completes a four-phase handshake. A small monitor watches the handshake. It raises an error pulse when the engine keeps acknowledge high after the peripheral has released its lines for longer than the one cycle it is allowed.

Top module: `dma_req_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, burst_req, single_req and proto_err are all low, and the requester is armed.
- R2: With IS_SOURCE=0 (sink), the available count is DEPTH minus fifo_level. An armed requester with acknowledge low raises single_req on the next cycle when that count is at least 1.
- R3: With IS_SOURCE=1 (source), the available count is fifo_level. An armed requester with acknowledge low raises single_req on the next cycle when that count is at least 1.
- R4: burst_req is raised together with single_req when burst_thresh is nonzero and the available count is at least burst_thresh. A burst_thresh of 0 disables burst requests, and burst_req is never high unless single_req is high.
- R5: Once raised, single_req stays high while acknowledge is low, whatever fifo_level does. burst_req stays high once raised, and it may also rise during a pending request if the threshold is reached.
- R6: The cycle after dma_ack is sampled high during a pending request, both request lines are low.
- R7: No request line rises while dma_ack is high. The requester arms again only after dma_ack has been sampled low following a release, and only then can it start a new request.
- R8: When the available count is 0, an armed requester raises no line.
- R9: proto_err is high for one cycle each time dma_ack has been sampled high, with both request lines low, on two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | CNT_W | FIFO occupancy, from 0 to DEPTH |
| burst_thresh | input | CNT_W | Count at which a burst is requested; 0 disables bursts |
| dma_ack | input | 1 | Acknowledge from the DMA engine |
| burst_req | output | 1 | Burst request to the DMA engine |
| single_req | output | 1 | At-least-one-item line to the DMA engine |
| proto_err | output | 1 | Pulse marking an acknowledge held too long |

## Verification
The assertions check the following on every cycle:
- both lines drop after acknowledge;
- a pending single line is held while acknowledge is low;
- no line rises while acknowledge is high after a release;
- burst never appears without single;
- a new single line rises only when the available count allows it;
- the error pulse is preceded by an unanswered acknowledge.

Only the bench scenarios can show the following:
- the exact threshold compare in each direction;
- that a disabled threshold suppresses bursts;
- that a burst can join a pending request;
- that level changes during a pending request have no effect.

The bench shows these by comparing both flavours against a behavioural model on every clock.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_PENDING = 2'd1,
    ST_RELEASE = 2'd2
  } req_state_e;
endpackage

// File: rtl/dma_req_avail.sv
module dma_req_avail #(
  parameter int DEPTH     = 16,
  parameter bit IS_SOURCE = 1'b0,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] burst_thresh,
  output logic             single_ok,
  output logic             burst_ok
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic [CNT_W-1:0] avail;

  generate
    if (IS_SOURCE) begin : g_source
      assign avail = fifo_level;
    end else begin : g_sink
      assign avail = (fifo_level >= DEPTH_V) ? '0 : (DEPTH_V - fifo_level);
    end
  endgenerate

  assign single_ok = (avail != '0);
  assign burst_ok  = (burst_thresh != '0) && (avail >= burst_thresh);
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic single_ok,
  input  logic burst_ok,
  input  logic dma_ack,
  output logic burst_req,
  output logic single_req
);
  req_state_e state_q, state_d;
  logic       burst_d, single_d;
  logic       out_en;

  always_comb begin
    state_d  = state_q;
    burst_d  = burst_req;
    single_d = single_req;
    unique case (state_q)
      ST_ARMED: begin
        if (!dma_ack && (single_ok || burst_ok)) begin
          state_d  = ST_PENDING;
          burst_d  = burst_ok;
          single_d = single_ok;
        end
      end
      ST_PENDING: begin
        if (dma_ack) begin
          state_d  = ST_RELEASE;
          burst_d  = 1'b0;
          single_d = 1'b0;
        end else begin
          burst_d = burst_req | burst_ok;
        end
      end
      ST_RELEASE: begin
        if (!dma_ack) state_d = ST_ARMED;
      end
      default: begin
        state_d  = ST_ARMED;
        burst_d  = 1'b0;
        single_d = 1'b0;
      end
    endcase
  end

  assign out_en = (burst_d != burst_req) || (single_d != single_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_req  <= 1'b0;
      single_req <= 1'b0;
    end else if (out_en) begin
      burst_req  <= burst_d;
      single_req <= single_d;
    end
  end
endmodule

// File: rtl/dma_req_ackmon.sv
module dma_req_ackmon (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_ack,
  input  logic burst_req,
  input  logic single_req,
  output logic proto_err
);
  logic idle_ack;
  logic stale_q, stale_d;
  logic err_d;

  always_comb begin
    idle_ack = dma_ack && !burst_req && !single_req;
    stale_d  = idle_ack;
    err_d    = idle_ack && stale_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      stale_q   <= stale_d;
      proto_err <= err_d;
    end
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int DEPTH     = 16,
  parameter bit IS_SOURCE = 1'b0,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] burst_thresh,
  input  logic             dma_ack,
  output logic             burst_req,
  output logic             single_req,
  output logic             proto_err
);
  logic single_ok, burst_ok;

  dma_req_avail #(
    .DEPTH(DEPTH), .IS_SOURCE(IS_SOURCE), .CNT_W(CNT_W)
  ) u_avail (
    .fifo_level  (fifo_level),
    .burst_thresh(burst_thresh),
    .single_ok   (single_ok),
    .burst_ok    (burst_ok)
  );

  dma_req_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .single_ok (single_ok),
    .burst_ok  (burst_ok),
    .dma_ack   (dma_ack),
    .burst_req (burst_req),
    .single_req(single_req)
  );

  dma_req_ackmon u_ackmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_ack   (dma_ack),
    .burst_req (burst_req),
    .single_req(single_req),
    .proto_err (proto_err)
  );
endmodule

// File: rtl/dma_req_gen_sva.sv
module dma_req_gen_sva #(
  parameter int DEPTH     = 16,
  parameter bit IS_SOURCE = 1'b0,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_level,
  input logic             dma_ack,
  input logic             burst_req,
  input logic             single_req,
  input logic             proto_err
);
  logic has_item;
  assign has_item = IS_SOURCE ? (fifo_level != '0)
                              : (int'(fifo_level) < DEPTH);

  // R6
  assert_drop_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_req && dma_ack) |=> (!single_req && !burst_req));

  // R5
  assert_hold_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_req && !dma_ack) |=> single_req);

  // R7
  assert_no_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !single_req && !burst_req) |=> (!single_req && !burst_req));

  // R4
  assert_burst_with_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> single_req);

  // R2 / R3 / R8
  assert_single_needs_item_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_req && !dma_ack && !has_item) |=> !single_req);

  // R9
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(dma_ack) && !$past(single_req)));
endmodule

bind dma_req_gen dma_req_gen_sva #(
  .DEPTH(DEPTH), .IS_SOURCE(IS_SOURCE), .CNT_W(CNT_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_level(fifo_level),
  .dma_ack   (dma_ack),
  .burst_req (burst_req),
  .single_req(single_req),
  .proto_err (proto_err)
);

// File: tb/dma_req_gen_bench.sv
module dma_req_gen_bench;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] fifo_level;
  logic [CNT_W-1:0] burst_thresh;
  logic             dma_ack;
  logic [1:0]       b_out, s_out, e_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // Model state per flavour: index 0 is the sink, index 1 is the source.
  int m_st [2];
  bit m_b [2], m_s [2], m_e [2], m_stale [2];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  dma_req_gen #(.DEPTH(DEPTH), .IS_SOURCE(1'b0)) u_dma_req_gen (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
    .burst_thresh(burst_thresh), .dma_ack(dma_ack),
    .burst_req(b_out[0]), .single_req(s_out[0]), .proto_err(e_out[0])
  );

  dma_req_gen #(.DEPTH(DEPTH), .IS_SOURCE(1'b1)) u_dma_req_gen_src (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
    .burst_thresh(burst_thresh), .dma_ack(dma_ack),
    .burst_req(b_out[1]), .single_req(s_out[1]), .proto_err(e_out[1])
  );

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_st[i] = 0; m_b[i] = 0; m_s[i] = 0; m_e[i] = 0; m_stale[i] = 0;
      end else begin
        int  av;
        bit  sc, bc, idle_ack;
        av = (i == 1) ? int'(fifo_level) : DEPTH - int'(fifo_level);
        if (av < 0) av = 0;
        sc = (av >= 1);
        bc = (burst_thresh != 0) && (av >= int'(burst_thresh));
        idle_ack   = dma_ack && !m_b[i] && !m_s[i];
        m_e[i]     = idle_ack && m_stale[i];
        m_stale[i] = idle_ack;
        case (m_st[i])
          0: if (!dma_ack && (sc || bc)) begin
               m_st[i] = 1; m_b[i] = bc; m_s[i] = sc;
             end
          1: if (dma_ack) begin
               m_st[i] = 2; m_b[i] = 0; m_s[i] = 0;
             end else begin
               m_b[i] = m_b[i] | bc;
             end
          default: if (!dma_ack) m_st[i] = 0;
        endcase
      end
    end
  end

  task automatic check_one(string what, int idx, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s[%0d] at %0t: actual %0b expected %0b",
               cur_req, what, idx, $time, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        check_one("burst_req",  i, b_out[i], m_b[i]);
        check_one("single_req", i, s_out[i], m_s[i]);
        check_one("proto_err",  i, e_out[i], m_e[i]);
      end
    end
  endtask

  task automatic drive(int lvl, int thr, bit ack);
    fifo_level   = CNT_W'(lvl);
    burst_thresh = CNT_W'(thr);
    dma_ack      = ack;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(8, 4, 0);
    cur_req = "R1";
    step(3);
    check_one("reset_single", 0, s_out[0], 1'b0);
    check_one("reset_burst",  1, b_out[1], 1'b0);
    drive(16, 0, 1);
    rst_n = 1'b1;
    step(1);

    // Source full, sink full: source requests with burst, sink stays quiet.
    cur_req = "R3";
    drive(16, 4, 0);
    step(3);
    check_one("src_burst_R4",  1, b_out[1], 1'b1);
    check_one("sink_quiet_R8", 0, s_out[0], 1'b0);
    cur_req = "R6";
    drive(16, 4, 1);
    step(1);
    check_one("drop_R6", 1, s_out[1], 1'b0);
    cur_req = "R9";
    step(2);
    cur_req = "R7";
    drive(16, 4, 0);
    step(3);

    // Sink with plenty of room, source empty.
    cur_req = "R2";
    drive(0, 4, 1);
    step(2);
    drive(0, 4, 0);
    step(3);
    check_one("sink_single_R2", 0, s_out[0], 1'b1);
    check_one("src_quiet_R8",   1, s_out[1], 1'b0);
    drive(0, 4, 1);
    step(1);
    drive(0, 4, 0);
    step(2);

    // Threshold boundary and burst joining a pending request.
    cur_req = "R5";
    drive(14, 4, 1);
    step(2);
    drive(14, 4, 0);
    step(2);
    drive(13, 4, 0);
    step(2);
    drive(12, 4, 0);
    step(2);
    check_one("burst_join_R5", 0, b_out[0], 1'b1);
    drive(16, 4, 0);
    step(3);
    check_one("hold_R5", 0, s_out[0], 1'b1);
    drive(16, 4, 1);
    step(1);
    drive(16, 4, 0);
    step(2);

    // Exact threshold for the source.
    cur_req = "R4";
    drive(3, 3, 1);
    step(2);
    drive(3, 3, 0);
    step(2);
    check_one("at_thresh_R4", 1, b_out[1], 1'b1);
    drive(3, 0, 1);
    step(1);
    drive(3, 0, 0);
    step(3);
    check_one("thresh_off_R4", 1, b_out[1], 1'b0);

    // Acknowledge held high for a long stretch.
    cur_req = "R7";
    drive(8, 2, 1);
    step(10);
    cur_req = "R9";
    drive(8, 2, 0);
    step(4);

    // Random stress.
    cur_req = "R5";
    for (int k = 0; k < 4000; k++) begin
      drive($urandom_range(0, DEPTH), $urandom_range(0, DEPTH),
            ($urandom_range(0, 3) == 0));
      step(1);
    end

    cur_req = "R1";
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(2);
    finish_run();
  end
endmodule